// File: doc/BRIEF.md
# Low-Side Driver Fault Supervisor

This block sits between four active-low channel commands and the gate drive of four low-side power switches. It qualifies the digitized sense flags of each channel (over-current, low load current, output voltage below threshold), turns faults into gate decisions, and records them in a sticky diagnostic register. Every qualification window is counted in ticks of one shared timebase, so the same logic serves any tick rate.

An over-current that outlasts its window turns the channel off and keeps it off until the command is released and asserted again. Low-current and output-low conditions only set diagnostic bits. The low-current window is chosen per channel between a long and a short value. The two highest channels can compare against a lower current limit. A shared over-temperature flag is recorded but never removes drive. A clear pulse from the serial side empties the diagnostic register. Reset or a supply-low indication turns every gate off and empties all counters, trip latches and diagnostic bits.

Top module: `lsd_fault_sup`

## Requirements
- R1: A channel's `gate_en` bit is 1 in the cycle after its `cmd_n` bit is sampled low, provided the channel is not tripped and `supply_ok` is 1; a high `cmd_n` bit gives `gate_en` 0 in the next cycle.
- R2: When the selected over-current flag of an enabled channel is high for SC_TICKS consecutive ticks, the channel's `gate_en` and `diag_sc` bits become 0 and 1 one cycle after the qualifying tick is registered; if the flag drops earlier, the count restarts from zero and nothing trips.
- R3: A tripped channel stays off while its `cmd_n` bit remains low, even after the over-current flag clears; it drives again only after `cmd_n` goes high and then low.
- R4: The `diag_ol` bit of a channel sets only while the channel is driving, after `ol_det` has been high for the open-load window; `td_ol_short` bit 0 selects OL_LONG_TICKS and bit 1 selects OL_SHORT_TICKS for that channel.
- R5: The `diag_sg` bit of a channel sets only while the channel is not driving, after `sg_det` has been high for SG_TICKS ticks.
- R6: `ot_flag` high sets `diag_tmp` in the next cycle and has no effect on any `gate_en` bit.
- R7: Reset, or `supply_ok` low, makes all `gate_en` and diagnostic bits 0 in the next cycle and empties all qualification counters and trip latches.
- R8: Channels 2 and 3 (zero-based) use `oc_low` bits 0 and 1 as their over-current flag when `isc_low` is 1 and their `oc_norm` bit when it is 0; channels 0 and 1 always use `oc_norm`.
- R9: Diagnostic bits are sticky: they clear only on reset, supply-low or a `diag_clr` pulse; a fault that is still qualified when the pulse arrives keeps its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| supply_ok | input | 1 | Low while the supply is below its operating threshold |
| tick | input | 1 | One-cycle timebase pulse for all windows |
| cmd_n | input | 4 | Active-low channel commands |
| oc_norm | input | 4 | Over-current flag at the default limit, per channel |
| oc_low | input | 2 | Over-current flag at the reduced limit, channels 2 and 3 |
| ol_det | input | 4 | Load current below open-load threshold, per channel |
| sg_det | input | 4 | Output voltage below short-to-ground threshold, per channel |
| ot_flag | input | 1 | Shared over-temperature flag |
| td_ol_short | input | 4 | Per channel: 1 selects the short open-load window |
| isc_low | input | 1 | 1 selects the reduced current limit on channels 2 and 3 |
| diag_clr | input | 1 | One-cycle clear of the diagnostic register |
| gate_en | output | 4 | Gate drive enables |
| diag_sc | output | 4 | Sticky over-current trip bits |
| diag_ol | output | 4 | Sticky open-load bits |
| diag_sg | output | 4 | Sticky short-to-ground bits |
| diag_tmp | output | 1 | Sticky over-temperature bit |

## Verification
The hardest state to reach is a qualification window interrupted just before expiry and then restarted, since it differs from a clean trip only by one tick of count. The stimulus runs the over-current and output-low flags for one tick fewer than the window, drops them for a cycle, and reasserts them for another short run, expecting no trip; it then clears a diagnostic bit while its fault is still qualified and again after the fault went away, so both outcomes of the clear are seen at the ports.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    // Which over-current comparator a selectable channel listens to
    typedef enum logic {
        THR_DEFAULT = 1'b0,
        THR_REDUCED = 1'b1
    } oc_thr_e;

endpackage

// File: rtl/lsd_qual_cnt.sv
module lsd_qual_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         tick,
    input  logic         cond,
    input  logic [W-1:0] limit,
    output logic         hit
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         done;
    } qst_t;

    qst_t q, d;

    always_comb begin
        d = q;
        if (flush || !cond) begin
            d = '0;
        end else if (tick && !q.done) begin
            if (q.cnt == limit - W'(1)) begin
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Qualified level only while the condition is still present
    assign hit = q.done & cond & ~flush;

endmodule

// File: rtl/lsd_oc_sel.sv
module lsd_oc_sel
    import lsd_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NSEL = 2
) (
    input  logic [NCH-1:0]  oc_norm,
    input  logic [NSEL-1:0] oc_low,
    input  logic            isc_low,
    output logic [NCH-1:0]  oc_eff
);

    localparam int BASE = NCH - NSEL;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i >= BASE) begin : g_sel
            assign oc_eff[i] = (oc_thr_e'(isc_low) == THR_REDUCED) ?
                               oc_low[i-BASE] : oc_norm[i];
        end else begin : g_fix
            assign oc_eff[i] = oc_norm[i];
        end
    end

endmodule

// File: rtl/lsd_fault_sup.sv
module lsd_fault_sup #(
    parameter int NCH            = 4,
    parameter int NSEL           = 2,
    parameter int TW             = 16,
    parameter int SC_TICKS       = 3,
    parameter int OL_LONG_TICKS  = 400,
    parameter int OL_SHORT_TICKS = 46,
    parameter int SG_TICKS       = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            supply_ok,
    input  logic            tick,
    input  logic [NCH-1:0]  cmd_n,
    input  logic [NCH-1:0]  oc_norm,
    input  logic [NSEL-1:0] oc_low,
    input  logic [NCH-1:0]  ol_det,
    input  logic [NCH-1:0]  sg_det,
    input  logic            ot_flag,
    input  logic [NCH-1:0]  td_ol_short,
    input  logic            isc_low,
    input  logic            diag_clr,
    output logic [NCH-1:0]  gate_en,
    output logic [NCH-1:0]  diag_sc,
    output logic [NCH-1:0]  diag_ol,
    output logic [NCH-1:0]  diag_sg,
    output logic            diag_tmp
);

    localparam logic [TW-1:0] SC_LIM  = TW'(SC_TICKS);
    localparam logic [TW-1:0] OLL_LIM = TW'(OL_LONG_TICKS);
    localparam logic [TW-1:0] OLS_LIM = TW'(OL_SHORT_TICKS);
    localparam logic [TW-1:0] SG_LIM  = TW'(SG_TICKS);

    typedef struct packed {
        logic [NCH-1:0] gate;
        logic [NCH-1:0] trip;
        logic [NCH-1:0] sc;
        logic [NCH-1:0] ol;
        logic [NCH-1:0] sg;
        logic           tmp;
    } sup_t;

    sup_t q, d;

    logic [NCH-1:0] oc_eff;
    logic [NCH-1:0] sc_hit;
    logic [NCH-1:0] ol_hit;
    logic [NCH-1:0] sg_hit;
    logic           flush;

    assign flush = ~supply_ok;

    lsd_oc_sel #(
        .NCH  (NCH),
        .NSEL (NSEL)
    ) u_ocsel (
        .oc_norm (oc_norm),
        .oc_low  (oc_low),
        .isc_low (isc_low),
        .oc_eff  (oc_eff)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic [TW-1:0] ol_lim;
        assign ol_lim = td_ol_short[i] ? OLS_LIM : OLL_LIM;

        lsd_qual_cnt #(.W(TW)) u_sc (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush),
            .tick  (tick),
            .cond  (q.gate[i] & oc_eff[i]),
            .limit (SC_LIM),
            .hit   (sc_hit[i])
        );

        lsd_qual_cnt #(.W(TW)) u_ol (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush),
            .tick  (tick),
            .cond  (q.gate[i] & ol_det[i]),
            .limit (ol_lim),
            .hit   (ol_hit[i])
        );

        lsd_qual_cnt #(.W(TW)) u_sg (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (flush),
            .tick  (tick),
            .cond  (~q.gate[i] & sg_det[i]),
            .limit (SG_LIM),
            .hit   (sg_hit[i])
        );
    end

    always_comb begin
        d = q;
        // trip latch: set by a qualified over-current, released by command off
        d.trip = (q.trip | sc_hit) & ~cmd_n;
        d.gate = ~cmd_n & ~q.trip & ~sc_hit;
        // sticky diagnostics, a fresh qualification wins over a clear
        d.sc   = (diag_clr ? '0 : q.sc) | sc_hit;
        d.ol   = (diag_clr ? '0 : q.ol) | ol_hit;
        d.sg   = (diag_clr ? '0 : q.sg) | sg_hit;
        d.tmp  = (diag_clr ? 1'b0 : q.tmp) | ot_flag;
        if (!supply_ok) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign gate_en  = q.gate;
    assign diag_sc  = q.sc;
    assign diag_ol  = q.ol;
    assign diag_sg  = q.sg;
    assign diag_tmp = q.tmp;

endmodule

// File: rtl/lsd_fault_sup_chk.sv
module lsd_fault_sup_chk #(
    parameter int NCH  = 4,
    parameter int NSEL = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            supply_ok,
    input logic [NCH-1:0]  cmd_n,
    input logic            ot_flag,
    input logic [NCH-1:0]  gate_en,
    input logic [NCH-1:0]  diag_sc,
    input logic [NCH-1:0]  diag_ol,
    input logic [NCH-1:0]  diag_sg,
    input logic            diag_tmp
);

    for (genvar i = 0; i < NCH; i++) begin : g_c
        a_r1_gate_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en[i] |-> $past(!cmd_n[i]));

        a_r2_trip_cuts_gate: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(diag_sc[i]) |-> !gate_en[i]);

        a_r3_trip_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
            (supply_ok && $past(supply_ok) && $past(rst_n) && !gate_en[i]
             && !cmd_n[i] && $past(!cmd_n[i])) |=> !gate_en[i]);

        a_r4_ol_while_on: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(diag_ol[i]) |-> $past(gate_en[i]));

        a_r5_sg_while_off: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(diag_sg[i]) |-> !$past(gate_en[i]));
    end

    a_r6_tmp_records: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag && supply_ok) |=> diag_tmp);

    a_r7_supply_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (gate_en == '0 && diag_sc == '0 && diag_ol == '0
                        && diag_sg == '0 && !diag_tmp));

endmodule

bind lsd_fault_sup lsd_fault_sup_chk #(
    .NCH  (NCH),
    .NSEL (NSEL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .cmd_n     (cmd_n),
    .ot_flag   (ot_flag),
    .gate_en   (gate_en),
    .diag_sc   (diag_sc),
    .diag_ol   (diag_ol),
    .diag_sg   (diag_sg),
    .diag_tmp  (diag_tmp)
);

// File: tb/sim_lsd_fault_sup.sv
`timescale 1ns/1ps
module sim_lsd_fault_sup;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok;
    logic       tick;
    logic [3:0] cmd_n;
    logic [3:0] oc_norm;
    logic [1:0] oc_low;
    logic [3:0] ol_det;
    logic [3:0] sg_det;
    logic       ot_flag;
    logic [3:0] td_ol_short;
    logic       isc_low;
    logic       diag_clr;
    logic [3:0] gate_en, diag_sc, diag_ol, diag_sg;
    logic       diag_tmp;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lsd_fault_sup #(
        .NCH(4), .NSEL(2), .TW(8), .SC_TICKS(3),
        .OL_LONG_TICKS(12), .OL_SHORT_TICKS(4), .SG_TICKS(6)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .tick(tick),
        .cmd_n(cmd_n), .oc_norm(oc_norm), .oc_low(oc_low), .ol_det(ol_det),
        .sg_det(sg_det), .ot_flag(ot_flag), .td_ol_short(td_ol_short),
        .isc_low(isc_low), .diag_clr(diag_clr), .gate_en(gate_en),
        .diag_sc(diag_sc), .diag_ol(diag_ol), .diag_sg(diag_sg),
        .diag_tmp(diag_tmp)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // each tick: one cycle with tick high, one idle cycle
    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clr_pulse();
        diag_clr = 1'b1;
        @(negedge clk);
        diag_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic quiesce();
        cmd_n = 4'hF; oc_norm = '0; oc_low = '0; ol_det = '0; sg_det = '0;
        ot_flag = 1'b0; isc_low = 1'b0; td_ol_short = '0;
        cycles(2);
        clr_pulse();
    endtask

    task automatic t_reset();
        chk("R7 reset gate", gate_en, 0);
        chk("R7 reset diag", {diag_sc, diag_ol, diag_sg, 3'b0, diag_tmp}, 0);
    endtask

    task automatic t_cmd();
        cmd_n = 4'b1010;
        cycles(1);
        chk("R1 active-low command", gate_en, 4'b0101);
        cmd_n = 4'b0111;
        cycles(1);
        chk("R1 command change", gate_en, 4'b1000);
        quiesce();
    endtask

    task automatic t_sc();
        // interrupted window on ch1
        cmd_n = 4'b1101;
        cycles(1);
        oc_norm[1] = 1'b1;
        ticks(2);
        oc_norm[1] = 1'b0;
        cycles(1);
        oc_norm[1] = 1'b1;
        ticks(2);
        chk("R2 restart no trip sc", diag_sc, 0);
        chk("R2 restart gate on", gate_en, 4'b0010);
        oc_norm[1] = 1'b0;
        quiesce();
        // full window on ch0
        cmd_n = 4'b1110;
        cycles(1);
        oc_norm[0] = 1'b1;
        ticks(2);
        chk("R2 before window", {gate_en, diag_sc}, {4'b0001, 4'b0000});
        ticks(1);
        chk("R2 trip", {gate_en, diag_sc}, {4'b0000, 4'b0001});
    endtask

    task automatic t_relatch();
        oc_norm[0] = 1'b0;
        cycles(3);
        chk("R3 stays off with cmd low", gate_en, 0);
        cmd_n[0] = 1'b1;
        cycles(1);
        chk("R3 off while released", gate_en, 0);
        cmd_n[0] = 1'b0;
        cycles(1);
        chk("R3 re-enabled after toggle", gate_en, 4'b0001);
        quiesce();
    endtask

    task automatic t_isc();
        cmd_n = 4'b0011;
        cycles(1);
        isc_low = 1'b0;
        oc_low = 2'b01;
        ticks(3);
        chk("R8 reduced flag ignored at default", {gate_en, diag_sc}, {4'b1100, 4'b0000});
        isc_low = 1'b1;
        oc_norm[3] = 1'b1;
        ticks(3);
        chk("R8 reduced limit trips ch2 only", {gate_en, diag_sc}, {4'b1000, 4'b0100});
        quiesce();
    endtask

    task automatic t_ol();
        td_ol_short = 4'b0010;
        cmd_n = 4'b1100;
        cycles(1);
        ol_det = 4'b0111;
        ticks(4);
        chk("R4 short window", diag_ol, 4'b0010);
        ticks(7);
        chk("R4 long window not yet", diag_ol, 4'b0010);
        ticks(1);
        chk("R4 long window and off channel", diag_ol, 4'b0011);
        quiesce();
    endtask

    task automatic t_sg();
        cmd_n = 4'b0111;
        cycles(1);
        sg_det = 4'b1001;
        ticks(5);
        chk("R5 before window", diag_sg, 0);
        ticks(1);
        chk("R5 off channel only", diag_sg, 4'b0001);
    endtask

    task automatic t_sticky();
        clr_pulse();
        chk("R9 clear while qualified", diag_sg, 4'b0001);
        sg_det = 4'b0000;
        cycles(1);
        chk("R9 sticky after cause gone", diag_sg, 4'b0001);
        clr_pulse();
        chk("R9 clear after cause gone", diag_sg, 0);
        sg_det = 4'b0001;
        ticks(5);
        chk("R9 requalify restarts", diag_sg, 0);
        ticks(1);
        chk("R9 requalified", diag_sg, 4'b0001);
        quiesce();
    endtask

    task automatic t_tmp();
        cmd_n = 4'b1101;
        ot_flag = 1'b1;
        cycles(1);
        ot_flag = 1'b0;
        cycles(2);
        chk("R6 tmp set gate kept", {gate_en, 3'b0, diag_tmp}, {4'b0010, 4'b0001});
        clr_pulse();
        chk("R6 tmp cleared", diag_tmp, 0);
        quiesce();
    endtask

    task automatic t_supply();
        cmd_n = 4'b0000;
        ot_flag = 1'b1;
        sg_det = 4'b0000;
        cycles(2);
        ot_flag = 1'b0;
        supply_ok = 1'b0;
        cycles(1);
        chk("R7 supply low gate", gate_en, 0);
        chk("R7 supply low diag", diag_tmp, 0);
        supply_ok = 1'b1;
        cycles(1);
        chk("R7 supply back", gate_en, 4'hF);
        quiesce();
    endtask

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1; tick = 1'b0; cmd_n = 4'hF;
        oc_norm = '0; oc_low = '0; ol_det = '0; sg_det = '0; ot_flag = 1'b0;
        td_ol_short = '0; isc_low = 1'b0; diag_clr = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_cmd();
        t_sc();
        t_relatch();
        t_isc();
        t_ol();
        t_sg();
        t_sticky();
        t_tmp();
        t_supply();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule